// File: doc/BRIEF.md
# Two-Range SPI Serial Clock Generator

This block turns the system clock into the serial clock of an SPI master. A 5-bit prescale code sets the division ratio. The code works in two ranges: a direct range for small ratios and a doubled range for large even ratios.

The block also applies the idle level and edge phase settings of SCK. It tells the neighbouring shift logic when to act by issuing two single-cycle strobes: one to launch the next output bit and one to capture the incoming bit. A capture-edge select moves input capture to the opposite internal edge, which helps at the fastest ratios.

The transfer sequencer holds the enable high for the length of a transfer. While the enable is low, the ratio is re-read from the code and SCK rests at its idle level. Every new enable starts a fresh SCK period.

Top module: `spi_sck_prescaler`

## Requirements
- R1: While reset is asserted, SCK is high (the idle level of the default mode, polarity 1 and phase 1), and both strobes are low.
- R2: A prescale code below 16 (bit 4 clear) gives a division ratio equal to the code, except that codes 0 and 1 give a ratio of 2.
- R3: A prescale code with bit 4 set gives a ratio of twice its bits 3..0, with a minimum of 2. Codes 24 to 31 therefore give even ratios from 16 to 30.
- R4: For a ratio R, the enable is first sampled high at clock edge E0. After edge Ek, with m = (k+1) mod R, SCK is at its active level (the inverse of the polarity input) exactly when m >= R - floor(R/2). So the idle half lasts ceil(R/2) cycles and the active half lasts floor(R/2) cycles.
- R5: SCK equals the polarity input one cycle after any edge at which the enable is sampled low. No strobe is issued in that cycle.
- R6: Each rising of the enable restarts the divider, so the first leading edge again appears after edge E(ceil(R/2)-1).
- R7: The launch strobe is a one-cycle pulse in the cycle where SCK takes its new level. It fires on trailing edges (SCK returning to idle) when phase is 0, and on leading edges when phase is 1.
- R8: The sample strobe fires on leading edges when the phase input equals the capture-edge select input, and on trailing edges otherwise.
- R9: The prescale code is captured only while the enable is low. A code change while enabled has no effect until the next enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable from the transfer sequencer |
| presc_i | input | 5 | Two-range prescale code |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | 0: capture on first edge; 1: launch on first edge |
| capt_i | input | 1 | Move data capture to the other internal edge |
| sck_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle strobe to shift out the next bit |
| sample_o | output | 1 | One-cycle strobe to capture the input bit |

## Verification
A wrong latched ratio, or a counter that misses its limit, shows up as the first leading edge at the wrong position. That happens within ceil(R/2) cycles of enable, and the error repeats every period after. A phase register that is out of step inverts SCK against the cycle model at once, and moves each strobe onto the opposite edge. A strobe mapped to the wrong edge is seen at the first edge of a run, by the SCK level in the strobe cycle.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

    localparam int PRESC_W = 5;
    localparam int LOW_W   = PRESC_W - 1;
    localparam int RATIO_W = PRESC_W;
    localparam int HALF_W  = PRESC_W - 1;
    localparam int MIN_RATIO = 2;

    // idle level of SCK while reset is held (polarity 1 of the default mode)
    localparam logic RESET_SCK = 1'b1;

    typedef logic [PRESC_W-1:0] presc_t;
    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [HALF_W-1:0]  half_t;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } sck_phase_t;

    typedef struct packed {
        half_t idle_len;   // cycles at idle level
        half_t act_len;    // cycles at active level
    } halves_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic capt;
    } sck_mode_t;

    function automatic ratio_t code_to_ratio(input presc_t code);
        ratio_t r;
        if (code[PRESC_W-1])
            r = {code[LOW_W-1:0], 1'b0};
        else
            r = ratio_t'(code);
        if (r < ratio_t'(MIN_RATIO))
            r = ratio_t'(MIN_RATIO);
        return r;
    endfunction

    function automatic halves_t split_ratio(input ratio_t r);
        halves_t h;
        ratio_t  idle_full;
        h.act_len = r[RATIO_W-1:1];
        idle_full = r - {1'b0, r[RATIO_W-1:1]};
        h.idle_len = idle_full[HALF_W-1:0];
        return h;
    endfunction

endpackage

// File: rtl/sck_ratio_latch.sv
module sck_ratio_latch
    import spi_sck_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  presc_t  code,
    output halves_t halves_q
);

    halves_t halves_d;

    always_comb begin
        halves_d = split_ratio(code_to_ratio(code));
    end

    always_ff @(posedge clk) begin
        if (rst)
            halves_q <= split_ratio(ratio_t'(MIN_RATIO));
        else if (!en)
            halves_q <= halves_d;
    end

    // R9
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> $stable(halves_q));

    // R2
    half_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (halves_q.idle_len != '0) && (halves_q.act_len != '0));

    // R4
    half_order_chk: assert property (@(posedge clk) disable iff (rst)
        (halves_q.idle_len >= halves_q.act_len) &&
        (halves_q.idle_len - halves_q.act_len <= half_t'(1)));

endmodule

// File: rtl/sck_half_timer.sv
module sck_half_timer
    import spi_sck_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  halves_t    halves,
    output logic       lead_hit,
    output logic       trail_hit,
    output sck_phase_t phase_nxt
);

    half_t      cnt_q;
    sck_phase_t phase_q;
    half_t      cur_len;
    logic       hit;

    always_comb begin
        cur_len   = (phase_q == PH_IDLE) ? halves.idle_len : halves.act_len;
        hit       = en && (cnt_q == cur_len - half_t'(1));
        lead_hit  = hit && (phase_q == PH_IDLE);
        trail_hit = hit && (phase_q == PH_ACTIVE);
        if (!en)
            phase_nxt = PH_IDLE;
        else if (hit)
            phase_nxt = (phase_q == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
        else
            phase_nxt = phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q   <= '0;
            phase_q <= PH_IDLE;
        end else if (hit) begin
            cnt_q   <= '0;
            phase_q <= phase_nxt;
        end else begin
            cnt_q   <= cnt_q + half_t'(1);
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q < cur_len));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0) && (phase_q == PH_IDLE));

endmodule

// File: rtl/sck_strobe_out.sv
module sck_strobe_out
    import spi_sck_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  sck_mode_t  mode,
    input  sck_phase_t phase_nxt,
    input  logic       lead_hit,
    input  logic       trail_hit,
    output logic       sck_o,
    output logic       launch_o,
    output logic       sample_o
);

    logic launch_d;
    logic sample_d;

    always_comb begin
        launch_d = mode.cpha ? lead_hit : trail_hit;
        sample_d = (mode.cpha == mode.capt) ? lead_hit : trail_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_o    <= RESET_SCK;
            launch_o <= 1'b0;
            sample_o <= 1'b0;
        end else begin
            sck_o    <= mode.cpol ^ (phase_nxt == PH_ACTIVE);
            launch_o <= launch_d;
            sample_o <= sample_d;
        end
    end

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sck_o == $past(mode.cpol)) && !launch_o && !sample_o);

    // R7
    launch_edge_chk: assert property (@(posedge clk) disable iff (rst)
        launch_o |-> (sck_o != $past(sck_o)) &&
                     (sck_o == ($past(mode.cpol) ^ $past(mode.cpha))));

    // R8
    sample_edge_chk: assert property (@(posedge clk) disable iff (rst)
        sample_o |-> (sck_o != $past(sck_o)));

    // R7
    launch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        launch_o |=> !launch_o);

endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
    import spi_sck_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic               cpol_i,
    input  logic               cpha_i,
    input  logic               capt_i,
    output logic               sck_o,
    output logic               launch_o,
    output logic               sample_o
);

    halves_t    halves;
    sck_mode_t  mode;
    sck_phase_t phase_nxt;
    logic       lead_hit;
    logic       trail_hit;

    always_comb begin
        mode.cpol = cpol_i;
        mode.cpha = cpha_i;
        mode.capt = capt_i;
    end

    sck_ratio_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .en       (en_i),
        .code     (presc_i),
        .halves_q (halves)
    );

    sck_half_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .en        (en_i),
        .halves    (halves),
        .lead_hit  (lead_hit),
        .trail_hit (trail_hit),
        .phase_nxt (phase_nxt)
    );

    sck_strobe_out u_out (
        .clk       (clk),
        .rst       (rst),
        .en        (en_i),
        .mode      (mode),
        .phase_nxt (phase_nxt),
        .lead_hit  (lead_hit),
        .trail_hit (trail_hit),
        .sck_o     (sck_o),
        .launch_o  (launch_o),
        .sample_o  (sample_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> sck_o && !launch_o && !sample_o);

endmodule

// File: tb/test_spi_sck_prescaler.sv
module test_spi_sck_prescaler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0;
    logic [4:0] presc_i = 5'd0;
    logic       cpol_i = 1'b0;
    logic       cpha_i = 1'b0;
    logic       capt_i = 1'b0;
    logic       sck_o, launch_o, sample_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_sck_prescaler i_spi_sck_prescaler (
        .clk(clk), .rst(rst), .en_i(en_i), .presc_i(presc_i),
        .cpol_i(cpol_i), .cpha_i(cpha_i), .capt_i(capt_i),
        .sck_o(sck_o), .launch_o(launch_o), .sample_o(sample_o)
    );

    // {code[12:8], ratio[7:3], cpol[2], cpha[1], capt[0]}
    localparam logic [12:0] VEC [12] = '{
        {5'd0,  5'd2,  3'b111},
        {5'd1,  5'd2,  3'b000},
        {5'd2,  5'd2,  3'b010},
        {5'd3,  5'd3,  3'b110},
        {5'd5,  5'd5,  3'b100},
        {5'd15, 5'd15, 3'b001},
        {5'd7,  5'd7,  3'b011},
        {5'd16, 5'd2,  3'b110},
        {5'd17, 5'd2,  3'b101},
        {5'd20, 5'd8,  3'b010},
        {5'd24, 5'd16, 3'b111},
        {5'd31, 5'd30, 3'b100}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic [4:0] code, input logic pol, input logic pha, input logic cap);
        @(negedge clk);
        en_i = 1'b0; presc_i = code; cpol_i = pol; cpha_i = pha; capt_i = cap;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    // enables at the current negedge and checks ncyc cycles against the model
    task automatic run(input int r, input int ncyc, input int chg_k,
                       input logic [4:0] chg_code, input string tag);
        int bad_s = 0, bad_l = 0, bad_m = 0;
        int a_s = 0, e_s = 0, a_l = 0, e_l = 0, a_m = 0, e_m = 0;
        en_i = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            int m, l0;
            bit ph, ld, tr, xs, xl, xm;
            @(posedge clk);
            @(negedge clk);
            m  = (k + 1) % r;
            l0 = r - r / 2;
            ph = (m >= l0);
            ld = (m == l0);
            tr = (m == 0);
            xs = cpol_i ^ ph;
            xl = cpha_i ? ld : tr;
            xm = (cpha_i == capt_i) ? ld : tr;
            if (sck_o !== xs && bad_s == 0) begin a_s = sck_o; e_s = xs; end
            if (sck_o !== xs) bad_s++;
            if (launch_o !== xl && bad_l == 0) begin a_l = launch_o; e_l = xl; end
            if (launch_o !== xl) bad_l++;
            if (sample_o !== xm && bad_m == 0) begin a_m = sample_o; e_m = xm; end
            if (sample_o !== xm) bad_m++;
            if (k == chg_k) presc_i = chg_code;
        end
        chk(bad_s == 0, {tag, " sck"}, a_s, e_s);
        chk(bad_l == 0, {tag, " R7 launch"}, a_l, e_l);
        chk(bad_m == 0, {tag, " R8 sample"}, a_m, e_m);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with polarity input 0
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sck_o == 1'b1,    "R1 sck", sck_o, 1);
        chk(launch_o == 1'b0, "R1 launch", launch_o, 0);
        chk(sample_o == 1'b0, "R1 sample", sample_o, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(sck_o == 1'b0, "R5 idle after reset", sck_o, 0);

        // table walk: R2/R3 ratios, R4 waveform, R7/R8 strobes
        for (int i = 0; i < 12; i++) begin
            logic [4:0] code;
            int r;
            code = VEC[i][12:8];
            r = int'(VEC[i][7:3]);
            setup(code, VEC[i][2], VEC[i][1], VEC[i][0]);
            run(r, 3 * r + 2, -1, 5'd0, code[4] ? "R3 R4" : "R2 R4");
        end

        // R5: enable dropped during the active half
        setup(5'd10, 1'b0, 1'b1, 1'b0);
        run(10, 7, -1, 5'd0, "R4");
        en_i = 1'b0;
        begin
            int bad = 0;
            for (int k = 0; k < 4; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (sck_o !== 1'b0 || launch_o || sample_o) bad++;
            end
            chk(bad == 0, "R5 idle while disabled", bad, 0);
        end

        // R6 restart, R9 code change while enabled is ignored
        run(10, 30, 2, 5'd2, "R6 R9");
        @(negedge clk);
        en_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        run(2, 6, -1, 5'd0, "R9 reload");

        // R5: idle level follows polarity 1
        @(negedge clk);
        en_i = 1'b0; cpol_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(sck_o == 1'b1, "R5 idle cpol1", sck_o, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule